// File: doc/BRIEF.md
# Modulo Reservation Table

This block holds the resource occupancy of one loop iteration during modulo scheduling, for an initiation interval (II) that can be changed while running. It keeps one row per functional resource: two ALUs, one memory port, two buses and one branch unit. Each row has one bit per slot of the interval. A lookup gives a resource number and a 16-bit schedule time T. The block reduces T modulo II, reports whether that slot is free for that resource and, when asked to commit, claims it. A claim at time T therefore blocks every time congruent to T modulo II.

A scheduler drives it like this. It loads a candidate interval, which also empties the table. It then queries and commits each operation in turn. It releases entries when it unschedules an operation. If placement fails, it loads the next larger interval and starts over. A commit to a slot that is already taken is refused, the table keeps its contents, and a conflict flag is raised in the same cycle.

Top module: `mrt_table`

## Requirements
- R1: After reset, ii_o is 1 and every entry of every row is free.
- R2: slot_o always equals req_time_i modulo ii_o, exactly, for any 16-bit time and any interval from 1 to 16.
- R3: free_o is high in the same cycle exactly when req_valid_i is high, req_res_i is below 6, and the entry (req_res_i, slot_o) is not busy. Resource numbers are 0 ALU0, 1 ALU1, 2 memory, 3 bus0, 4 bus1 and 5 branch.
- R4: A commit (req_valid_i and req_commit_i) to a free entry makes that entry busy from the next cycle. No other entry changes.
- R5: A commit to a busy entry raises conflict_o in the same cycle and leaves the table unchanged.
- R6: Once (R, T) is claimed, every time T' with T' mod II equal to T mod II reads as busy for R. Other resources are not affected.
- R7: A release (rel_valid_i) frees entry (rel_res_i, rel_time_i mod II) from the next cycle. Releasing an entry that is already free changes nothing.
- R8: ii_load_i with ii_val_i between 1 and 16 sets ii_o to that value on the next cycle and frees all entries in that one cycle. This wins over a commit, release or clear in the same cycle.
- R9: ii_load_i with ii_val_i equal to 0 or above 16 is ignored. ii_o and the table stay as they were.
- R10: clear_i frees all entries in one cycle and keeps ii_o.
- R11: A request with req_res_i of 6 or 7 gives free_o low and conflict_o low, and changes no entry.
- R12: When a commit and a release happen in the same cycle, the commit is judged on the table as it was before the clock edge. The release is still applied. So a free entry that is committed and released together ends up busy. A busy entry that is committed and released together gives a conflict and ends up free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ii_load_i | input | 1 | Load a new interval and empty the table |
| ii_val_i | input | 5 | Interval to load, 1 to 16 |
| clear_i | input | 1 | Empty the table and keep the interval |
| req_valid_i | input | 1 | Query is active |
| req_commit_i | input | 1 | Claim the queried entry if it is free |
| req_res_i | input | 3 | Resource number of the query |
| req_time_i | input | 16 | Schedule time of the query |
| rel_valid_i | input | 1 | Release is active |
| rel_res_i | input | 3 | Resource number to release |
| rel_time_i | input | 16 | Schedule time to release |
| ii_o | output | 5 | Current interval |
| slot_o | output | 4 | req_time_i modulo the interval |
| free_o | output | 1 | Queried entry is free |
| conflict_o | output | 1 | Commit refused because the entry is busy |
| busy_row_o | output | 16 | Occupancy row of req_res_i (zero when the number is above 5) |

## Verification
The bench checks the reduction for every interval from 1 to 16, using times near 0, 2^16-1 and other values that a wrong remainder stage would get wrong. An off-by-one in a subtract stage would show up there as a wrong slot. It claims one time and then looks up congruent times far away, including 40000 for II 3. A table indexed by raw time, or by a truncated time, would report those as free. It commits to busy entries, loads intervals that are out of range, and issues same-cycle commit and release pairs. A design that overwrote on conflict, accepted an interval of 0 or 17, or let a release hide a busy bit from the commit check would leave a different row in busy_row_o on the next cycle. Invalid resource numbers 6 and 7 are also tried, because they could alias onto a real row.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
  localparam int NUM_RES = 6;
  localparam int MAX_II  = 16;
  localparam int T_W     = 16;
  localparam int RES_W   = $clog2(NUM_RES);
  localparam int II_W    = $clog2(MAX_II + 1);
  localparam int SLOT_W  = $clog2(MAX_II);

  typedef enum logic [RES_W-1:0] {
    RES_ALU0 = 3'd0,
    RES_ALU1 = 3'd1,
    RES_MEM  = 3'd2,
    RES_BUS0 = 3'd3,
    RES_BUS1 = 3'd4,
    RES_BR   = 3'd5
  } res_id_e;
endpackage

// File: rtl/mrt_mod_reduce.sv
// Restoring remainder, one conditional subtract per time bit.
module mrt_mod_reduce #(
  parameter int T_W = 16,
  parameter int D_W = 5
) (
  input  logic [T_W-1:0] t_i,
  input  logic [D_W-1:0] d_i,
  output logic [D_W-1:0] rem_o
);
  logic [D_W-1:0] part [T_W+1];
  logic [D_W-1:0] shf  [T_W];

  assign part[0] = '0;

  for (genvar g = 0; g < T_W; g++) begin : g_stage
    // part < d <= 2^(D_W-1), so the top bit is zero and may be dropped
    assign shf[g]    = {part[g][D_W-2:0], t_i[T_W-1-g]};
    assign part[g+1] = (shf[g] >= d_i) ? (shf[g] - d_i) : shf[g];
  end

  assign rem_o = part[T_W];
endmodule

// File: rtl/mrt_row.sv
module mrt_row #(
  parameter int MAX_II = 16,
  localparam int SLOT_W = $clog2(MAX_II)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wipe_i,
  input  logic              set_i,
  input  logic [SLOT_W-1:0] set_idx_i,
  input  logic              clr_i,
  input  logic [SLOT_W-1:0] clr_idx_i,
  output logic [MAX_II-1:0] occ_o
);
  logic [MAX_II-1:0] set_mask, clr_mask, occ_d, occ_q;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (set_i) set_mask[set_idx_i] = 1'b1;
    if (clr_i) clr_mask[clr_idx_i] = 1'b1;
    occ_d = wipe_i ? '0 : ((occ_q & ~clr_mask) | set_mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= occ_d;
  end

  assign occ_o = occ_q;
endmodule

// File: rtl/mrt_table.sv
module mrt_table
  import mrt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ii_load_i,
  input  logic [II_W-1:0]   ii_val_i,
  input  logic              clear_i,
  input  logic              req_valid_i,
  input  logic              req_commit_i,
  input  logic [RES_W-1:0]  req_res_i,
  input  logic [T_W-1:0]    req_time_i,
  input  logic              rel_valid_i,
  input  logic [RES_W-1:0]  rel_res_i,
  input  logic [T_W-1:0]    rel_time_i,
  output logic [II_W-1:0]   ii_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              free_o,
  output logic              conflict_o,
  output logic [MAX_II-1:0] busy_row_o
);
  localparam int OCC_W = NUM_RES * MAX_II;

  logic [II_W-1:0]   ii_q;
  logic              load_ok, wipe;
  logic [II_W-1:0]   req_rem, rel_rem;
  logic [SLOT_W-1:0] req_slot, rel_slot;
  logic              req_res_ok, rel_res_ok;
  logic [MAX_II-1:0] occ [NUM_RES];
  logic [OCC_W-1:0]  occ_flat;
  logic [MAX_II-1:0] req_row;
  logic              req_busy, commit_ok;

  assign load_ok = ii_load_i && (ii_val_i != '0) && (ii_val_i <= II_W'(MAX_II));
  assign wipe    = load_ok || clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ii_q <= II_W'(1);
    else if (load_ok) ii_q <= ii_val_i;
  end

  mrt_mod_reduce #(.T_W(T_W), .D_W(II_W)) u_req_mod (
    .t_i(req_time_i), .d_i(ii_q), .rem_o(req_rem)
  );
  mrt_mod_reduce #(.T_W(T_W), .D_W(II_W)) u_rel_mod (
    .t_i(rel_time_i), .d_i(ii_q), .rem_o(rel_rem)
  );

  assign req_slot   = req_rem[SLOT_W-1:0];
  assign rel_slot   = rel_rem[SLOT_W-1:0];
  assign req_res_ok = (req_res_i < RES_W'(NUM_RES));
  assign rel_res_ok = (rel_res_i < RES_W'(NUM_RES));

  always_comb begin
    req_row = '0;
    for (int r = 0; r < NUM_RES; r++)
      if (req_res_i == RES_W'(r)) req_row = occ[r];
  end

  assign req_busy  = req_row[req_slot];
  assign free_o    = req_valid_i && req_res_ok && !req_busy;
  assign conflict_o = req_valid_i && req_commit_i && req_res_ok && req_busy;
  assign commit_ok = free_o && req_commit_i;

  for (genvar r = 0; r < NUM_RES; r++) begin : g_row
    mrt_row #(.MAX_II(MAX_II)) u_row (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wipe_i   (wipe),
      .set_i    (commit_ok && (req_res_i == RES_W'(r))),
      .set_idx_i(req_slot),
      .clr_i    (rel_valid_i && rel_res_ok && (rel_res_i == RES_W'(r))),
      .clr_idx_i(rel_slot),
      .occ_o    (occ[r])
    );
    assign occ_flat[r*MAX_II +: MAX_II] = occ[r];
  end

  assign ii_o       = ii_q;
  assign slot_o     = req_slot;
  assign busy_row_o = req_row;
endmodule

// File: rtl/mrt_table_chk.sv
module mrt_table_chk
  import mrt_pkg::*;
(
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      ii_load_i,
  input logic [II_W-1:0]           ii_val_i,
  input logic                      clear_i,
  input logic                      req_valid_i,
  input logic                      req_commit_i,
  input logic [RES_W-1:0]          req_res_i,
  input logic                      rel_valid_i,
  input logic [II_W-1:0]           ii_o,
  input logic [SLOT_W-1:0]         slot_o,
  input logic                      free_o,
  input logic                      conflict_o,
  input logic [NUM_RES*MAX_II-1:0] occ_flat
);
  logic [$clog2(NUM_RES*MAX_II)-1:0] cidx;
  logic ld_good;

  assign cidx    = ($clog2(NUM_RES*MAX_II))'(int'(req_res_i) * MAX_II + int'(slot_o));
  assign ld_good = ii_load_i && ii_val_i != '0 && ii_val_i <= II_W'(MAX_II);

  a_r1_ii_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ii_o != '0) && (ii_o <= II_W'(MAX_II)));

  a_r2_slot_below_ii: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (II_W'(slot_o) < ii_o));

  a_r4_commit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_o && req_commit_i && !ii_load_i && !clear_i) |=> occ_flat[$past(cidx)]);

  a_r5_conflict_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conflict_o && !rel_valid_i && !ii_load_i && !clear_i) |=> $stable(occ_flat));

  a_r8_load_wipes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_good |=> (occ_flat == '0) && (ii_o == $past(ii_val_i)));

  a_r11_bad_res: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_res_i >= RES_W'(NUM_RES)) |-> (!free_o && !conflict_o));
endmodule

bind mrt_table mrt_table_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ii_load_i   (ii_load_i),
  .ii_val_i    (ii_val_i),
  .clear_i     (clear_i),
  .req_valid_i (req_valid_i),
  .req_commit_i(req_commit_i),
  .req_res_i   (req_res_i),
  .rel_valid_i (rel_valid_i),
  .ii_o        (ii_o),
  .slot_o      (slot_o),
  .free_o      (free_o),
  .conflict_o  (conflict_o),
  .occ_flat    (occ_flat)
);

// File: tb/sim_mrt_table.sv
`timescale 1ns/1ps
module sim_mrt_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ii_load = 1'b0;
  logic [4:0]  ii_val = '0;
  logic        clear = 1'b0;
  logic        req_valid = 1'b0, req_commit = 1'b0;
  logic [2:0]  req_res = '0;
  logic [15:0] req_time = '0;
  logic        rel_valid = 1'b0;
  logic [2:0]  rel_res = '0;
  logic [15:0] rel_time = '0;
  logic [4:0]  ii;
  logic [3:0]  slot;
  logic        free, conflict;
  logic [15:0] row;

  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  mrt_table u0 (
    .clk_i(clk), .rst_ni(rst_n), .ii_load_i(ii_load), .ii_val_i(ii_val),
    .clear_i(clear), .req_valid_i(req_valid), .req_commit_i(req_commit),
    .req_res_i(req_res), .req_time_i(req_time), .rel_valid_i(rel_valid),
    .rel_res_i(rel_res), .rel_time_i(rel_time), .ii_o(ii), .slot_o(slot),
    .free_o(free), .conflict_o(conflict), .busy_row_o(row)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ii_load = 0; clear = 0; req_valid = 0; req_commit = 0; rel_valid = 0;
  endtask

  // Apply inputs for one edge, then return at the following falling edge.
  task automatic tick();
    @(posedge clk); #1; idle(); @(negedge clk);
  endtask

  task automatic load(int v);
    ii_load = 1; ii_val = 5'(v); tick();
  endtask

  task automatic commit(int r, int t);
    req_valid = 1; req_commit = 1; req_res = 3'(r); req_time = 16'(t); tick();
  endtask

  task automatic query(int r, int t);
    req_valid = 1; req_commit = 0; req_res = 3'(r); req_time = 16'(t); #1;
  endtask

  task automatic row_of(int r);
    req_valid = 0; req_res = 3'(r); #1;
  endtask

  task automatic t_reset();
    chk("R1 ii", ii, 1);
    for (int r = 0; r < 6; r++) begin
      row_of(r); chk("R1 row", row, 0);
    end
    query(0, 12345); chk("R1 free", free, 1);
    idle();
  endtask

  task automatic t_mod();
    int tv[9] = '{0, 1, 15, 16, 17, 255, 1000, 12345, 65535};
    for (int d = 1; d <= 16; d++) begin
      load(d);
      chk("R8 ii loaded", ii, d);
      for (int k = 0; k < 9; k++) begin
        query(0, tv[k]); chk("R2 slot", slot, tv[k] % d);
      end
      idle();
    end
  endtask

  task automatic t_congruence();
    load(3);
    query(0, 7); chk("R3 free before", free, 1); idle();
    commit(0, 7);
    row_of(0); chk("R4 row", row, 16'h0002);
    row_of(1); chk("R4 other row", row, 0);
    query(0, 1);     chk("R6 congruent 1", free, 0);
    query(0, 40000); chk("R6 congruent 40000", free, 0);
    query(0, 8);     chk("R3 other slot", free, 1);
    query(1, 7);     chk("R6 other res", free, 1);
    idle();
  endtask

  task automatic t_conflict();
    query(0, 4); req_commit = 1; #1;
    chk("R5 conflict", conflict, 1); chk("R5 free low", free, 0);
    tick();
    row_of(0); chk("R5 row kept", row, 16'h0002);
  endtask

  task automatic t_release();
    rel_valid = 1; rel_res = 3'd0; rel_time = 16'd13; tick();
    row_of(0); chk("R7 freed", row, 0);
    commit(2, 5);
    rel_valid = 1; rel_res = 3'd2; rel_time = 16'd0; tick();
    row_of(2); chk("R7 free release no effect", row, 16'h0004);
  endtask

  task automatic t_bad_res();
    commit(1, 0);
    for (int r = 6; r < 8; r++) begin
      query(r, 0); req_commit = 1; #1;
      chk("R11 free", free, 0); chk("R11 conflict", conflict, 0);
      chk("R11 row", row, 0);
      tick();
    end
    row_of(0); chk("R11 row0", row, 0);
    row_of(1); chk("R11 row1", row, 16'h0001);
    row_of(2); chk("R11 row2", row, 16'h0004);
  endtask

  task automatic t_bad_load();
    load(0);  chk("R9 ii after 0", ii, 3);
    load(17); chk("R9 ii after 17", ii, 3);
    row_of(2); chk("R9 row kept", row, 16'h0004);
  endtask

  task automatic t_clear();
    clear = 1; tick();
    chk("R10 ii kept", ii, 3);
    row_of(1); chk("R10 row1", row, 0);
    row_of(2); chk("R10 row2", row, 0);
  endtask

  task automatic t_load_wipe();
    commit(4, 1);
    ii_load = 1; ii_val = 5'd5;
    req_valid = 1; req_commit = 1; req_res = 3'd4; req_time = 16'd2;
    tick();
    chk("R8 ii", ii, 5);
    row_of(4); chk("R8 load wins", row, 0);
  endtask

  task automatic t_same_cycle();
    load(4);
    req_valid = 1; req_commit = 1; req_res = 3'd3; req_time = 16'd2;
    rel_valid = 1; rel_res = 3'd3; rel_time = 16'd6; #1;
    chk("R12 free on old state", free, 1);
    tick();
    row_of(3); chk("R12 commit kept", row, 16'h0004);
    req_valid = 1; req_commit = 1; req_res = 3'd3; req_time = 16'd10;
    rel_valid = 1; rel_res = 3'd3; rel_time = 16'd2; #1;
    chk("R12 conflict on old state", conflict, 1);
    tick();
    row_of(3); chk("R12 release applied", row, 0);
  endtask

  task automatic t_max_ii();
    load(16);
    commit(5, 65535);
    row_of(5); chk("R4 top slot", row, 16'h8000);
    query(5, 15); chk("R6 congruent at 16", free, 0);
    query(5, 16); chk("R6 slot 0 free", free, 1);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mod();
    t_congruence();
    t_conflict();
    t_release();
    t_bad_res();
    t_bad_load();
    t_clear();
    t_load_wipe();
    t_same_cycle();
    t_max_ii();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule